// File: doc/BRIEF.md
# Horizontal Chroma Downsampler

This block takes a 4:4:4 pixel stream with 10-bit luma and two 10-bit chroma components. It halves the horizontal chroma resolution, so each line carries one Cb/Cr pair for every two pixels. Pixels move on a valid/ready handshake, and markers flag the first and last pixel of each line. Every input pixel produces exactly one output pixel, in the same order. Luma goes through unchanged, apart from optional 8-bit narrowing. An output flag, `o_cvalid`, marks the pixels that carry a chroma pair.

An 8-bit mode word sets the behaviour. It holds a block enable, a horizontal enable, a two-bit reduction method and an 8-bit output select. Four methods are available: keep the even sample, average the pair, a co-sited 11-tap FIR, and an off-sited 12-tap FIR. Both filters have fixed symmetric taps that sum to 512. Filter results are rounded and clamped to the 10-bit range.

Near the ends of a line, the filter needs samples that lie outside the line. It uses copies of the first or last pixel instead. To make those copies at the right edge, the block drains its window after each line's last pixel. It holds its input not-ready during this drain.

Top module: `chroma_hdown`

## Requirements
- R1: When mode bit 0 (block enable) or mode bit 1 (horizontal enable) is clear, every output pixel has `o_cvalid`=1 and carries its own input Cb and Cr.
- R2: With both enables set and method bits [4:3]=0 (drop), `o_cvalid` is 1 on even pixel indices and 0 on odd ones. Pixel index 0 is the pixel marked start-of-line. An even pixel carries its own chroma, and an odd pixel carries 0 in both chroma outputs.
- R3: Method 1 (average) gives pixel 2k the value (c[2k] + c[2k+1] + 1) >> 1 for each chroma component.
- R4: Method 2 (co-sited) weights c[2k+d] for d = -5..5 by 22, 0, -52, 0, 158, 256, 158, 0, -52, 0, 22. It adds 256, shifts right arithmetically by 9 and clamps the result to 0..1023.
- R5: Method 3 (off-sited) weights c[2k+d] for d = -5..6 by 5, 11, -21, -37, 70, 228, 228, 70, -37, -21, 11, 5. It then rounds, shifts and clamps in the same way as R4.
- R6: A sample index below 0 reads pixel 0 of the line, and an index past the end reads the last pixel. This holds for lines of any length, including 1.
- R7: When mode bit 7 is set, every luma and chroma output v becomes min((v + 2) >> 2, 255).
- R8: Each accepted input pixel yields one output pixel, in order. `o_sol` is set on index 0 and `o_eol` on the last index. Luma equals the input luma, narrowed per R7.
- R9: While `o_valid` is high and `o_ready` is low, the output pixel and its flags hold steady. No pixel is lost or repeated under any pattern of ready and valid.
- R10: A mode write takes effect from the next start-of-line pixel accepted in a later cycle. A write during a line leaves the rest of that line unchanged.
- R11: After reset, `o_valid` is low, `i_ready` is high and the mode is pass-through with 10-bit output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Mode word write strobe |
| cfg_wdata | input | 8 | Mode word: bit0 enable, bit1 horizontal enable, [4:3] method, bit7 8-bit output |
| i_valid | input | 1 | Input pixel valid |
| i_ready | output | 1 | Input pixel accepted when high with i_valid |
| i_sol | input | 1 | Input pixel is first of line |
| i_eol | input | 1 | Input pixel is last of line |
| i_y | input | 10 | Input luma |
| i_cb | input | 10 | Input blue-difference chroma |
| i_cr | input | 10 | Input red-difference chroma |
| o_valid | output | 1 | Output pixel valid |
| o_ready | input | 1 | Downstream ready |
| o_sol | output | 1 | Output pixel is first of line |
| o_eol | output | 1 | Output pixel is last of line |
| o_cvalid | output | 1 | Output pixel carries a chroma pair |
| o_y | output | 10 | Output luma |
| o_cb | output | 10 | Output Cb |
| o_cr | output | 10 | Output Cr |

## Verification
The bench targets the following corner cases:
- **Line ends.** The right-edge drain must copy the last pixel exactly. A design that flushed with zeros, or ran one step short, would corrupt the final chroma values or lose the last pixel and its end marker. Lines of length 1 and 3 push every tap past the edge.
- **Clamping.** Hand-built chroma steps drive the co-sited filter above 1023 and below 0. A missing clamp or an unsigned shift would wrap these values.
- **8-bit mode.** Values at the top of the range check that the rounded narrowing saturates at 255 rather than wrapping.
- **Mid-line mode write.** A write made during a line must leave the rest of that line under the old method.
- **Throttling.** Random stalls on both sides would expose a window that shifts while output is blocked.

// File: rtl/hcd_pkg.sv
package hcd_pkg;
    localparam int PW      = 10;
    localparam int NTAP    = 12;
    localparam int CENTER  = 6;
    localparam int LEAD    = NTAP - CENTER;
    localparam int COEF_W  = 10;
    localparam int ACC_W   = PW + COEF_W + 4;
    localparam int FRAC    = 9;
    localparam int NARROW_MAX = 255;

    typedef logic [PW-1:0] samp_t;

    typedef struct packed {
        samp_t y;
        samp_t cb;
        samp_t cr;
    } pix_t;

    typedef enum logic [1:0] {
        M_DROP    = 2'd0,
        M_AVG     = 2'd1,
        M_COSITE  = 2'd2,
        M_OFFSITE = 2'd3
    } meth_e;

    typedef struct packed {
        logic  reduce;
        logic  narrow;
        meth_e meth;
    } mode_t;

    typedef enum logic [1:0] {W_HOLD, W_FILL, W_PUSH, W_REPEAT} wop_e;

    function automatic mode_t decode_mode(input logic [7:0] w);
        mode_t m;
        m.reduce = w[0] & w[1];
        m.narrow = w[7];
        m.meth   = meth_e'(w[4:3]);
        return m;
    endfunction

    // Tap weight by window slot; slot 0 is the newest sample, slot CENTER the output phase.
    function automatic logic signed [COEF_W-1:0] tap(input meth_e m, input int i);
        logic signed [COEF_W-1:0] t;
        t = '0;
        if (m == M_COSITE) begin
            case (i)
                1, 11:   t = 10'sd22;
                3, 9:    t = -10'sd52;
                5, 7:    t = 10'sd158;
                6:       t = 10'sd256;
                default: t = '0;
            endcase
        end else if (m == M_OFFSITE) begin
            case (i)
                0, 11:   t = 10'sd5;
                1, 10:   t = 10'sd11;
                2, 9:    t = -10'sd21;
                3, 8:    t = -10'sd37;
                4, 7:    t = 10'sd70;
                5, 6:    t = 10'sd228;
                default: t = '0;
            endcase
        end
        return t;
    endfunction

    function automatic samp_t to_depth(input samp_t v, input logic narrow);
        logic [PW:0] r;
        r = ({1'b0, v} + (PW+1)'(2)) >> 2;
        if (r > (PW+1)'(NARROW_MAX)) r = (PW+1)'(NARROW_MAX);
        return narrow ? samp_t'(r) : v;
    endfunction
endpackage

// File: rtl/hcd_ctrl.sv
module hcd_ctrl
    import hcd_pkg::*;
#(
    parameter int LINE_W = 13
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_we,
    input  logic [7:0] cfg_wdata,
    input  logic       i_valid,
    input  logic       i_sol,
    input  logic       i_eol,
    input  logic       can_step,
    output logic       i_ready,
    output wop_e       op,
    output mode_t      mode_use,
    output mode_t      mode_act,
    output logic       nv,
    output logic       nsol,
    output logic       neol,
    output logic       neven
);
    localparam int IW = LINE_W + 1;
    localparam logic signed [IW-1:0] START = IW'(-LEAD);

    logic signed [IW-1:0] cidx, cidx_n, last;
    logic  flushing, take, fstep;
    mode_t shadow, active;

    assign i_ready  = can_step & ~flushing;
    assign take     = i_valid & i_ready;
    assign fstep    = flushing & can_step;
    assign mode_act = active;

    always_comb begin
        op     = W_HOLD;
        cidx_n = cidx;
        if (take) begin
            op     = i_sol ? W_FILL : W_PUSH;
            cidx_n = i_sol ? START : cidx + IW'(1);
        end else if (fstep) begin
            op     = W_REPEAT;
            cidx_n = cidx + IW'(1);
        end
        mode_use = (take & i_sol) ? shadow : active;
        nv       = (take | fstep) & ~cidx_n[IW-1];
        nsol     = (cidx_n == '0);
        neol     = fstep & (cidx_n == last);
        neven    = ~cidx_n[0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cidx     <= START;
            last     <= '0;
            flushing <= 1'b0;
            shadow   <= '0;
            active   <= '0;
        end else begin
            if (cfg_we) shadow <= decode_mode(cfg_wdata);
            if (take | fstep) cidx <= cidx_n;
            if (take & i_sol) active <= shadow;
            if (take & i_eol) begin
                flushing <= 1'b1;
                last     <= cidx_n + IW'(LEAD);
            end
            if (fstep && cidx_n == last) flushing <= 1'b0;
        end
    end

    // R10: the applied mode only moves when a start-of-line pixel is taken
    assert_mode_at_sol_R10: assert property (@(posedge clk) disable iff (rst)
        !(take && i_sol) |=> $stable(active));
endmodule

// File: rtl/hcd_win.sv
module hcd_win
    import hcd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  wop_e op,
    input  pix_t din,
    output pix_t nxt [NTAP]
);
    pix_t w [NTAP];

    for (genvar i = 0; i < NTAP; i++) begin : g_slot
        if (i == 0) begin : g_head
            assign nxt[i] = (op == W_FILL || op == W_PUSH) ? din : w[i];
        end else begin : g_body
            assign nxt[i] = (op == W_FILL) ? din :
                            (op == W_HOLD) ? w[i] : w[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NTAP; i++) w[i] <= '0;
        end else begin
            w <= nxt;
        end
    end
endmodule

// File: rtl/hcd_filt.sv
module hcd_filt
    import hcd_pkg::*;
(
    input  samp_t win [NTAP],
    input  meth_e meth,
    output samp_t res
);
    localparam logic signed [ACC_W-1:0] HALF = ACC_W'(1) <<< (FRAC - 1);
    localparam logic signed [ACC_W-1:0] HI   = ACC_W'((1 << PW) - 1);

    logic signed [ACC_W-1:0] acc, rnd, s, c;
    logic [PW:0] pair;
    samp_t clamped;

    always_comb begin
        acc = '0;
        for (int i = 0; i < NTAP; i++) begin
            s   = ACC_W'(signed'({1'b0, win[i]}));
            c   = ACC_W'(tap(meth, i));
            acc = acc + s * c;
        end
        rnd = (acc + HALF) >>> FRAC;
        if (rnd < 0)       clamped = '0;
        else if (rnd > HI) clamped = '1;
        else               clamped = samp_t'(rnd);

        pair = {1'b0, win[CENTER]} + {1'b0, win[CENTER-1]} + (PW+1)'(1);
        case (meth)
            M_DROP:  res = win[CENTER];
            M_AVG:   res = samp_t'(pair >> 1);
            default: res = clamped;
        endcase
    end
endmodule

// File: rtl/chroma_hdown.sv
module chroma_hdown
    import hcd_pkg::*;
#(
    parameter int LINE_W = 13
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_we,
    input  logic [7:0]    cfg_wdata,
    input  logic          i_valid,
    output logic          i_ready,
    input  logic          i_sol,
    input  logic          i_eol,
    input  logic [PW-1:0] i_y,
    input  logic [PW-1:0] i_cb,
    input  logic [PW-1:0] i_cr,
    output logic          o_valid,
    input  logic          o_ready,
    output logic          o_sol,
    output logic          o_eol,
    output logic          o_cvalid,
    output logic [PW-1:0] o_y,
    output logic [PW-1:0] o_cb,
    output logic [PW-1:0] o_cr
);
    localparam int NCOMP = 2;

    logic  can_step, nv, nsol, neol, neven;
    wop_e  op;
    mode_t mode_use, mode_act;
    pix_t  din;
    pix_t  nxt [NTAP];
    samp_t fres [NCOMP];

    assign din      = '{y: i_y, cb: i_cb, cr: i_cr};
    assign can_step = ~o_valid | o_ready;

    hcd_ctrl #(.LINE_W(LINE_W)) u_ctrl (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .i_valid(i_valid), .i_sol(i_sol), .i_eol(i_eol), .can_step(can_step),
        .i_ready(i_ready), .op(op), .mode_use(mode_use), .mode_act(mode_act),
        .nv(nv), .nsol(nsol), .neol(neol), .neven(neven)
    );

    hcd_win u_win (.clk(clk), .rst(rst), .op(op), .din(din), .nxt(nxt));

    for (genvar c = 0; c < NCOMP; c++) begin : g_comp
        samp_t cw [NTAP];
        for (genvar i = 0; i < NTAP; i++) begin : g_t
            assign cw[i] = (c == 0) ? nxt[i].cb : nxt[i].cr;
        end
        hcd_filt u_filt (.win(cw), .meth(mode_use.meth), .res(fres[c]));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            o_valid  <= 1'b0;
            o_sol    <= 1'b0;
            o_eol    <= 1'b0;
            o_cvalid <= 1'b0;
            o_y      <= '0;
            o_cb     <= '0;
            o_cr     <= '0;
        end else if (can_step) begin
            o_valid <= nv;
            o_sol   <= nsol;
            o_eol   <= neol;
            o_y     <= to_depth(nxt[CENTER].y, mode_use.narrow);
            if (mode_use.reduce) begin
                o_cvalid <= neven;
                o_cb     <= neven ? to_depth(fres[0], mode_use.narrow) : '0;
                o_cr     <= neven ? to_depth(fres[1], mode_use.narrow) : '0;
            end else begin
                o_cvalid <= 1'b1;
                o_cb     <= to_depth(nxt[CENTER].cb, mode_use.narrow);
                o_cr     <= to_depth(nxt[CENTER].cr, mode_use.narrow);
            end
        end
    end

    // R9: a stalled output pixel keeps its value
    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        o_valid && !o_ready |=> o_valid && $stable(o_y) && $stable(o_cb) &&
        $stable(o_cr) && $stable(o_sol) && $stable(o_eol) && $stable(o_cvalid));

    // R7: narrowed output never exceeds the 8-bit range
    assert_narrow_R7: assert property (@(posedge clk) disable iff (rst)
        o_valid && mode_act.narrow |-> o_y <= 10'd255 && o_cb <= 10'd255 && o_cr <= 10'd255);

    // R2: index 0 is even, so it always carries chroma
    assert_sol_chroma_R2: assert property (@(posedge clk) disable iff (rst)
        o_valid && o_sol |-> o_cvalid);

    // R8: the pixel after a line end opens a new line
    assert_eol_then_sol_R8: assert property (@(posedge clk) disable iff (rst)
        o_valid && o_ready && o_eol |=> !o_valid || o_sol);
endmodule

// File: tb/chroma_hdown_tb_top.sv
module chroma_hdown_tb_top;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst;
    logic cfg_we;
    logic [7:0] cfg_wdata;
    logic i_valid, i_ready, i_sol, i_eol;
    logic [9:0] i_y, i_cb, i_cr;
    logic o_valid, o_ready, o_sol, o_eol, o_cvalid;
    logic [9:0] o_y, o_cb, o_cr;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;
    int rdy_pct = 100;
    int vld_pct = 100;
    logic [7:0] shadow_m = 8'h00;

    int ly[$], lcb[$], lcr[$];
    int q_y[$], q_cb[$], q_cr[$], q_cv[$], q_sol[$], q_eol[$];
    string q_tag[$];
    bit q_nar[$];

    bit held = 0;
    int h_y, h_cb, h_cr, h_cv, h_sol, h_eol;

    always #(CLK_PERIOD/2) clk = ~clk;

    chroma_hdown dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .i_valid(i_valid), .i_ready(i_ready), .i_sol(i_sol), .i_eol(i_eol),
        .i_y(i_y), .i_cb(i_cb), .i_cr(i_cr),
        .o_valid(o_valid), .o_ready(o_ready), .o_sol(o_sol), .o_eol(o_eol),
        .o_cvalid(o_cvalid), .o_y(o_y), .o_cb(o_cb), .o_cr(o_cr)
    );

    task automatic chk(string tag, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int at(int c[$], int i);
        if (i < 0) return c[0];
        if (i > c.size() - 1) return c[c.size() - 1];
        return c[i];
    endfunction

    function automatic int nar(int v, bit en);
        int r;
        if (!en) return v;
        r = (v + 2) >> 2;
        return (r > 255) ? 255 : r;
    endfunction

    function automatic int ref_c(int c[$], int j, int meth);
        int acc, v;
        case (meth)
            0: return at(c, j);
            1: return (at(c, j) + at(c, j+1) + 1) / 2;
            2: acc = 256*at(c, j) + 158*(at(c, j-1) + at(c, j+1))
                     - 52*(at(c, j-3) + at(c, j+3)) + 22*(at(c, j-5) + at(c, j+5));
            default: acc = 228*(at(c, j) + at(c, j+1)) + 70*(at(c, j-1) + at(c, j+2))
                     - 37*(at(c, j-2) + at(c, j+3)) - 21*(at(c, j-3) + at(c, j+4))
                     + 11*(at(c, j-4) + at(c, j+5)) + 5*(at(c, j-5) + at(c, j+6));
        endcase
        v = (acc + 256) >>> 9;
        if (v < 0) v = 0;
        if (v > 1023) v = 1023;
        return v;
    endfunction

    task automatic push_line(logic [7:0] m, string tag);
        bit red;
        int L;
        red = m[0] & m[1];
        L = ly.size();
        for (int j = 0; j < L; j++) begin
            q_y.push_back(nar(ly[j], m[7]));
            q_nar.push_back(m[7]);
            q_sol.push_back(j == 0);
            q_eol.push_back(j == L - 1);
            q_tag.push_back(tag);
            if (!red) begin
                q_cv.push_back(1);
                q_cb.push_back(nar(lcb[j], m[7]));
                q_cr.push_back(nar(lcr[j], m[7]));
            end else if (j % 2 == 0) begin
                q_cv.push_back(1);
                q_cb.push_back(nar(ref_c(lcb, j, int'(m[4:3])), m[7]));
                q_cr.push_back(nar(ref_c(lcr, j, int'(m[4:3])), m[7]));
            end else begin
                q_cv.push_back(0);
                q_cb.push_back(0);
                q_cr.push_back(0);
            end
        end
    endtask

    task automatic observe();
        string tag;
        if (held) begin
            chk("R9 stall valid", int'(o_valid), 1);
            chk("R9 stall y", int'(o_y), h_y);
            chk("R9 stall cb", int'(o_cb), h_cb);
            chk("R9 stall cr", int'(o_cr), h_cr);
            chk("R9 stall flags", int'({o_cvalid, o_sol, o_eol}), (h_cv << 2) | (h_sol << 1) | h_eol);
        end
        held = o_valid && !o_ready;
        h_y = int'(o_y); h_cb = int'(o_cb); h_cr = int'(o_cr);
        h_cv = int'(o_cvalid); h_sol = int'(o_sol); h_eol = int'(o_eol);
        if (o_valid && o_ready) begin
            if (q_y.size() == 0) begin
                chk("R8 unexpected output pixel", 1, 0);
            end else begin
                tag = q_tag.pop_front();
                chk(q_nar[0] ? "R7 luma narrow" : "R8 luma", int'(o_y), q_y.pop_front());
                void'(q_nar.pop_front());
                chk("R8 sol", int'(o_sol), q_sol.pop_front());
                chk("R8 eol", int'(o_eol), q_eol.pop_front());
                chk({tag, " cvalid"}, int'(o_cvalid), q_cv[0]);
                if (q_cv.pop_front() == 1) begin
                    chk({tag, " cb"}, int'(o_cb), q_cb[0]);
                    chk({tag, " cr"}, int'(o_cr), q_cr[0]);
                end
                void'(q_cb.pop_front());
                void'(q_cr.pop_front());
            end
        end
    endtask

    task automatic build(int L, int pat);
        ly.delete(); lcb.delete(); lcr.delete();
        for (int k = 0; k < L; k++) begin
            case (pat)
                0: begin ly.push_back((k*37) % 1024); lcb.push_back((k*61 + 5) % 1024);
                         lcr.push_back(1023 - (k*29) % 1024); end
                1: begin ly.push_back($urandom_range(1023)); lcb.push_back($urandom_range(1023));
                         lcr.push_back($urandom_range(1023)); end
                2: begin ly.push_back(1020 + k % 4); lcb.push_back((k == 3) ? 0 : 1023);
                         lcr.push_back((k == 3 || k == 9) ? 1023 : 0); end
                default: begin ly.push_back(1023 - k % 3); lcb.push_back(1018 + k % 6);
                         lcr.push_back((k % 2) ? 1023 : 3); end
            endcase
        end
    endtask

    // cfg_idx: pixel index on whose first offer cycle a mode write is made (-1: none)
    task automatic send_line(int L, int pat, string tag, int cfg_idx, logic [7:0] cfg_val);
        int k;
        bit done;
        k = 0;
        done = 0;
        build(L, pat);
        while (k < L) begin
            @(negedge clk);
            cfg_we  = 1'b0;
            o_ready = ($urandom_range(99) < rdy_pct);
            if (k == cfg_idx && !done) begin
                cfg_we = 1'b1;
                cfg_wdata = cfg_val;
                done = 1;
            end
            i_valid = ($urandom_range(99) < vld_pct);
            i_sol = (k == 0);
            i_eol = (k == L - 1);
            i_y = 10'(ly[k]); i_cb = 10'(lcb[k]); i_cr = 10'(lcr[k]);
            #1;
            observe();
            if (i_valid && i_ready) begin
                if (k == 0) push_line(shadow_m, tag);
                k++;
            end
            if (cfg_we) shadow_m = cfg_wdata;
        end
        @(negedge clk);
        i_valid = 1'b0;
        cfg_we = 1'b0;
        o_ready = ($urandom_range(99) < rdy_pct);
        #1;
        observe();
    endtask

    task automatic write_mode(logic [7:0] v);
        @(negedge clk);
        i_valid = 1'b0;
        cfg_we = 1'b1;
        cfg_wdata = v;
        o_ready = ($urandom_range(99) < rdy_pct);
        #1;
        observe();
        shadow_m = v;
        @(negedge clk);
        cfg_we = 1'b0;
        o_ready = ($urandom_range(99) < rdy_pct);
        #1;
        observe();
    endtask

    task automatic drain();
        int n;
        n = 0;
        while (q_y.size() > 0 && n < 3000) begin
            @(negedge clk);
            i_valid = 1'b0;
            cfg_we = 1'b0;
            o_ready = ($urandom_range(99) < rdy_pct);
            #1;
            observe();
            n++;
        end
        chk("R8 all pixels delivered", q_y.size(), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_fail++;
            $display("FAIL R8 watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1234));
        rst = 1'b1; cfg_we = 1'b0; cfg_wdata = '0;
        i_valid = 1'b0; i_sol = 1'b0; i_eol = 1'b0;
        i_y = '0; i_cb = '0; i_cr = '0; o_ready = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R11 reset o_valid", int'(o_valid), 0);
        chk("R11 reset i_ready", int'(i_ready), 1);

        // R11 and R1: default mode is pass-through
        send_line(16, 0, "R11 default", -1, 8'h00);
        drain();
        // R1: horizontal enable without block enable still passes
        write_mode(8'h02);
        send_line(14, 1, "R1 pass", -1, 8'h00);
        drain();
        // R1: block enable alone passes
        write_mode(8'h01);
        send_line(9, 1, "R1 pass", -1, 8'h00);
        drain();

        rdy_pct = 60; vld_pct = 70;
        write_mode(8'h03);
        send_line(16, 1, "R2 drop", -1, 8'h00);
        drain();
        write_mode(8'h0B);
        send_line(15, 1, "R3 avg", -1, 8'h00);
        drain();
        write_mode(8'h13);
        send_line(20, 1, "R4 cosite", -1, 8'h00);
        send_line(16, 2, "R4 cosite clamp", -1, 8'h00);
        drain();
        write_mode(8'h1B);
        send_line(21, 1, "R5 offsite", -1, 8'h00);
        send_line(16, 2, "R5 offsite", -1, 8'h00);
        drain();

        // R6: short lines push every tap past the edges
        rdy_pct = 100; vld_pct = 100;
        write_mode(8'h13);
        send_line(1, 1, "R6 edge", -1, 8'h00);
        send_line(3, 1, "R6 edge", -1, 8'h00);
        write_mode(8'h1B);
        send_line(1, 1, "R6 edge", -1, 8'h00);
        send_line(2, 1, "R6 edge", -1, 8'h00);
        write_mode(8'h0B);
        send_line(7, 1, "R6 edge", -1, 8'h00);
        drain();

        // R7: narrow output with values near full scale
        rdy_pct = 50; vld_pct = 80;
        write_mode(8'h9B);
        send_line(12, 3, "R7 narrow", -1, 8'h00);
        write_mode(8'h80);
        send_line(10, 3, "R7 narrow", -1, 8'h00);
        drain();

        // R10: mid-line write, current line keeps averaging, next line is co-sited
        write_mode(8'h0B);
        send_line(18, 1, "R10 midline", 5, 8'h13);
        send_line(18, 1, "R10 next line", -1, 8'h00);
        drain();

        // R9: heavy throttling on both sides
        rdy_pct = 25; vld_pct = 40;
        write_mode(8'h1B);
        for (int n = 0; n < 6; n++) send_line(9 + n*3, 1, "R9 throttle", -1, 8'h00);
        drain();

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule